// File: doc/BRIEF.md
# Cache Burst-Fill Request Controller

This block sits between a cache and its bus interface and handles one read bus cycle at a time. When a cycle starts, it evaluates a set of inhibit conditions and decides whether to ask the bus for a burst that refills a whole 16-byte cache line. The inhibit inputs are the cache enable, the freeze bit, the burst-fill enable, a non-cacheable page flag and a read-modify-write read flag. An operand that runs past a line boundary is also inhibited. If no burst is requested, or the bus declines one, the cycle fills only the single 32-bit entry it touches.

When the bus grants a burst, the controller steps the fill address through the four long words of the line. It starts at the entry the access touched and wraps modulo the line size. For each beat it drives one write into the cache's tag/data array. The bus side can change the course of a cycle in three ways. A bus error stops the burst and marks the remaining entries invalid. A cache-inhibit reply on the first beat cancels all cache writes for the cycle. An acknowledge that drops partway through ends the burst early.

An operand that crosses a line is issued by the requester as two cycles. The first cycle never asks for a burst and writes only its own entry. The second cycle starts at offset zero of the next line and may burst normally.

The controller has four states:
- **IDLE** waits for a start. On `cyc_start` it goes to **FIRST**.
- **FIRST** handles the first beat. From there it goes to:
  - **BURST**, when the burst was requested and granted;
  - **FLUSH**, on a bus error during a requested burst;
  - **IDLE**, in every other case.
- **BURST** handles beats two to four. It goes to **FLUSH** on a bus error that is not on the last beat, and to **IDLE** after the last beat, on an early acknowledge drop, or on a bus error on the last beat.
- **FLUSH** invalidates one entry per clock and then returns to **IDLE**.

Top module: `burst_fill_ctrl`

## Requirements
- R1: In the first-beat cycle, `burst_req` is 1 exactly when all of these held at start: `cache_on`=1, `cache_frozen`=0, `burst_on`=1, `page_nocache`=0, `rmw_read`=0, and no line crossing. `burst_req` is 0 in every other cycle.
- R2: `cyc_size` is the operand byte count minus one. An access crosses when offset (address bits 3:0) plus `cyc_size` exceeds 15. A crossing access never requests a burst and writes only the entry at address bits 3:2.
- R3: `fill_addr` is the start line address with bits 3:2 equal to the current entry and bits 1:0 zero. Beats visit entries start, start+1, start+2 and start+3, each taken modulo 4. `ent_idx` follows the same order.
- R4: If `burst_ack` is 0 on the first beat, the cycle ends on that beat after a single-entry write.
- R5: A granted burst writes each of the four entries valid (`ent_we`=1, `ent_valid`=1), one per beat. `cyc_end` pulses on the fourth beat. No cache write occurs in the cycle after `cyc_end`.
- R6: A `berr` beat writes its entry invalid (`ent_valid`=0). If a burst was requested, each later entry in the sequence is then written invalid, one per clock, with `cyc_end` on the last one. A cycle with no burst request ends on the error beat.
- R7: `ci_in`=1 on a first beat without `berr` ends the cycle on that beat with no cache write.
- R8: A beat during the burst with `burst_ack`=0 writes its entry valid and ends the cycle.
- R9: When `cache_on`=0, `cache_frozen`=1 or `page_nocache`=1, the cycle makes no cache write. With `burst_on`=0 or `rmw_read`=1, the cycle still does a single-entry fill.
- R10: `cyc_start` and `cyc_addr` are ignored while a cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | Starts a read cycle (accepted in IDLE) |
| cyc_addr | input | 32 | Byte address of the access |
| cyc_size | input | 2 | Operand byte count minus one |
| cache_on | input | 1 | Target cache enabled |
| cache_frozen | input | 1 | Target cache frozen |
| burst_on | input | 1 | Burst fill enabled for the target cache |
| page_nocache | input | 1 | Page attribute marks access non-cacheable |
| rmw_read | input | 1 | Read part of a read-modify-write |
| beat | input | 1 | Bus transfer completes this clock |
| burst_ack | input | 1 | Bus grants or continues the burst |
| ci_in | input | 1 | Bus reports cache inhibit |
| berr | input | 1 | Bus error on this transfer |
| burst_req | output | 1 | Burst fill requested |
| fill_addr | output | 32 | Long-word address of the current transfer |
| ent_we | output | 1 | Write strobe into the cache entry |
| ent_idx | output | 2 | Entry index within the line |
| ent_valid | output | 1 | Valid bit value written with the entry |
| cyc_end | output | 1 | Last clock of the cycle |

## Verification
The bench covers the following corner cases.
- **Line-crossing operand:** a design that measured the operand from the wrong bit, or let the first half burst, would raise `burst_req` or write extra entries.
- **Start at a non-zero long word:** a controller that does not wrap would run the fill address into the next line.
- **Bus error in mid-burst and on the first beat:** a design that skipped invalidating the tail would leave stale valid entries, visible as missing writes in the scoreboard.
- **Early acknowledge drop, cache-inhibit reply and every inhibit input:** these are each run separately; mishandling any of them shows up as extra or missing writes.
- **Start pulse with a changed address mid-burst:** this catches a design that relatches the line address while busy.

// File: rtl/bfill_pkg.sv
package bfill_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_BURST = 2'd2,
        ST_FLUSH = 2'd3
    } bf_state_t;
endpackage

// File: rtl/bfill_gate.sv
// Evaluates the inhibit conditions for a new cycle.
module bfill_gate #(
    parameter int OFS_W  = 4,
    parameter int SIZE_W = 2
) (
    input  logic              cache_on,
    input  logic              cache_frozen,
    input  logic              burst_on,
    input  logic              page_nocache,
    input  logic              rmw_read,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [SIZE_W-1:0] size_m1,
    output logic              may_cache,
    output logic              want_burst
);
    logic [OFS_W:0] end_ofs;
    logic           crosses;

    always_comb begin
        end_ofs    = {1'b0, ofs} + {{(OFS_W + 1 - SIZE_W){1'b0}}, size_m1};
        crosses    = end_ofs[OFS_W];
        may_cache  = cache_on && !cache_frozen && !page_nocache;
        want_burst = may_cache && burst_on && !rmw_read && !crosses;
    end
endmodule

// File: rtl/bfill_wrap.sv
// Entry index for the current step, wrapping within the line.
module bfill_wrap #(
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0] start,
    input  logic [IDX_W-1:0] step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    always_comb begin
        idx  = start + step;
        last = (step == {IDX_W{1'b1}});
    end
endmodule

// File: rtl/burst_fill_ctrl.sv
module burst_fill_ctrl
    import bfill_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int WORD_BYTES = 4,
    parameter int SIZE_W     = 2,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int WB_W      = $clog2(WORD_BYTES),
    localparam int IDX_W     = OFS_W - WB_W,
    localparam int LINE_W    = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [SIZE_W-1:0] cyc_size,
    input  logic              cache_on,
    input  logic              cache_frozen,
    input  logic              burst_on,
    input  logic              page_nocache,
    input  logic              rmw_read,
    input  logic              beat,
    input  logic              burst_ack,
    input  logic              ci_in,
    input  logic              berr,
    output logic              burst_req,
    output logic [ADDR_W-1:0] fill_addr,
    output logic              ent_we,
    output logic [IDX_W-1:0]  ent_idx,
    output logic              ent_valid,
    output logic              cyc_end
);
    bf_state_t         state_q, state_d;
    logic [LINE_W-1:0] line_q, line_d;
    logic [IDX_W-1:0]  start_q, start_d;
    logic [IDX_W-1:0]  step_q, step_d;
    logic              want_q, want_d;
    logic              cache_q, cache_d;

    logic              may_cache, want_burst;
    logic [IDX_W-1:0]  cur_idx;
    logic              last_step;

    bfill_gate #(.OFS_W(OFS_W), .SIZE_W(SIZE_W)) i_gate (
        .cache_on     (cache_on),
        .cache_frozen (cache_frozen),
        .burst_on     (burst_on),
        .page_nocache (page_nocache),
        .rmw_read     (rmw_read),
        .ofs          (cyc_addr[OFS_W-1:0]),
        .size_m1      (cyc_size),
        .may_cache    (may_cache),
        .want_burst   (want_burst)
    );

    bfill_wrap #(.IDX_W(IDX_W)) i_wrap (
        .start (start_q),
        .step  (step_q),
        .idx   (cur_idx),
        .last  (last_step)
    );

    // Next-state and datapath capture
    always_comb begin
        state_d = state_q;
        line_d  = line_q;
        start_d = start_q;
        step_d  = step_q;
        want_d  = want_q;
        cache_d = cache_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cyc_start) begin
                    state_d = ST_FIRST;
                    line_d  = cyc_addr[ADDR_W-1:OFS_W];
                    start_d = cyc_addr[OFS_W-1:WB_W];
                    step_d  = '0;
                    want_d  = want_burst;
                    cache_d = may_cache;
                end
            end
            ST_FIRST: begin
                if (beat) begin
                    step_d = step_q + 1'b1;
                    if (berr)
                        state_d = want_q ? ST_FLUSH : ST_IDLE;
                    else if (!ci_in && want_q && burst_ack)
                        state_d = ST_BURST;
                    else
                        state_d = ST_IDLE;
                end
            end
            ST_BURST: begin
                if (beat) begin
                    step_d = step_q + 1'b1;
                    if (last_step)
                        state_d = ST_IDLE;
                    else if (berr)
                        state_d = ST_FLUSH;
                    else if (!burst_ack)
                        state_d = ST_IDLE;
                end
            end
            ST_FLUSH: begin
                step_d = step_q + 1'b1;
                if (last_step)
                    state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
            start_q <= '0;
            step_q  <= '0;
            want_q  <= 1'b0;
            cache_q <= 1'b0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
            start_q <= start_d;
            step_q  <= step_d;
            want_q  <= want_d;
            cache_q <= cache_d;
        end
    end

    // Outputs
    always_comb begin
        burst_req = 1'b0;
        ent_we    = 1'b0;
        ent_valid = 1'b0;
        ent_idx   = cur_idx;
        fill_addr = {line_q, cur_idx, {WB_W{1'b0}}};
        unique case (state_q)
            ST_IDLE: ;
            ST_FIRST: begin
                burst_req = want_q;
                if (beat) begin
                    ent_we    = cache_q && (berr || !ci_in);
                    ent_valid = !berr;
                end
            end
            ST_BURST: begin
                if (beat) begin
                    ent_we    = cache_q;
                    ent_valid = !berr;
                end
            end
            ST_FLUSH: begin
                ent_we    = cache_q;
                ent_valid = 1'b0;
            end
        endcase
        cyc_end = (state_q != ST_IDLE) && (state_d == ST_IDLE);
    end
endmodule

// File: rtl/bfill_chk.sv
module bfill_chk #(
    parameter int IDX_W  = 2,
    parameter int OFS_W  = 4,
    parameter int SIZE_W = 2,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_start,
    input logic [ADDR_W-1:0] cyc_addr,
    input logic [SIZE_W-1:0] cyc_size,
    input logic              cache_on,
    input logic              cache_frozen,
    input logic              burst_on,
    input logic              page_nocache,
    input logic              rmw_read,
    input logic              burst_req,
    input logic              ent_we,
    input logic [IDX_W-1:0]  ent_idx,
    input logic              ent_valid,
    input logic              cyc_end
);
    logic [OFS_W:0] end_ofs;
    assign end_ofs = {1'b0, cyc_addr[OFS_W-1:0]} + {{(OFS_W + 1 - SIZE_W){1'b0}}, cyc_size};

    assert_burst_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_req) |-> $past(cyc_start && cache_on && !cache_frozen && burst_on
                                   && !page_nocache && !rmw_read));

    assert_no_cross_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_req) |-> !$past(end_ofs[OFS_W]));

    assert_wrap_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_we && !cyc_end) |=> (!ent_we || ent_idx == $past(ent_idx) + 1'b1));

    assert_quiet_after_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> (!ent_we && !burst_req));

    assert_flush_continues_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_we && !ent_valid && !cyc_end) |=> (ent_we && !ent_valid));
endmodule

bind burst_fill_ctrl bfill_chk #(
    .IDX_W(IDX_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W), .ADDR_W(ADDR_W)
) i_bfill_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_start    (cyc_start),
    .cyc_addr     (cyc_addr),
    .cyc_size     (cyc_size),
    .cache_on     (cache_on),
    .cache_frozen (cache_frozen),
    .burst_on     (burst_on),
    .page_nocache (page_nocache),
    .rmw_read     (rmw_read),
    .burst_req    (burst_req),
    .ent_we       (ent_we),
    .ent_idx      (ent_idx),
    .ent_valid    (ent_valid),
    .cyc_end      (cyc_end)
);

// File: tb/test_burst_fill_ctrl.sv
`timescale 1ns/1ps
module test_burst_fill_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_start = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic [1:0]  cyc_size = '0;
    logic        cache_on = 1'b0, cache_frozen = 1'b0, burst_on = 1'b0;
    logic        page_nocache = 1'b0, rmw_read = 1'b0;
    logic        beat = 1'b0, burst_ack = 1'b0, ci_in = 1'b0, berr = 1'b0;
    logic        burst_req, ent_we, ent_valid, cyc_end;
    logic [31:0] fill_addr;
    logic [1:0]  ent_idx;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R0";
    logic [2:0] exp_q[$];

    always #10 clk = ~clk;

    burst_fill_ctrl i_burst_fill_ctrl (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
        .cyc_size(cyc_size), .cache_on(cache_on), .cache_frozen(cache_frozen),
        .burst_on(burst_on), .page_nocache(page_nocache), .rmw_read(rmw_read),
        .beat(beat), .burst_ack(burst_ack), .ci_in(ci_in), .berr(berr),
        .burst_req(burst_req), .fill_addr(fill_addr), .ent_we(ent_we),
        .ent_idx(ent_idx), .ent_valid(ent_valid), .cyc_end(cyc_end)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each cache write
    always @(negedge clk) begin
        #5;
        if (rst_n && ent_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected write: got idx %0d valid %0b expected none",
                         cur_tag, ent_idx, ent_valid);
            end else begin
                logic [2:0] e;
                e = exp_q.pop_front();
                if ({ent_idx, ent_valid} !== e) begin
                    errors++;
                    $display("FAIL %s write: got idx %0d valid %0b expected idx %0d valid %0b",
                             cur_tag, ent_idx, ent_valid, e[2:1], e[0]);
                end
            end
        end
    end

    // Driver: computes expectations, then plays one bus cycle
    task automatic run(input string tag, input logic [31:0] a, input logic [1:0] sz,
                       input logic en, input logic frz, input logic ben, input logic pnc,
                       input logic rmw, input logic ack0, input int drop_beat,
                       input int berr_beat, input logic ci, input logic poke);
        logic       crosses, cach, want, stop, berr_seen, ended;
        logic [1:0] st;
        int         exp_n, cyc;
        cur_tag = tag;
        crosses = ({1'b0, a[3:0]} + {3'b0, sz}) > 5'd15;
        cach    = en && !frz && !pnc;
        want    = cach && ben && !rmw && !crosses;
        st      = a[3:2];
        exp_n   = 1;
        if (berr_beat == 0) begin
            if (cach) exp_q.push_back({st, 1'b0});
            if (want) begin
                for (int j = 1; j < 4; j++) exp_q.push_back({2'(st + j), 1'b0});
                exp_n = 4;
            end
        end else if (!ci) begin
            if (cach) exp_q.push_back({st, 1'b1});
            if (want && ack0) begin
                exp_n = 4;
                stop  = 1'b0;
                for (int k = 1; k < 4; k++) begin
                    if (!stop) begin
                        if (k == berr_beat) begin
                            for (int j = k; j < 4; j++) exp_q.push_back({2'(st + j), 1'b0});
                            stop = 1'b1;
                        end else begin
                            exp_q.push_back({2'(st + k), 1'b1});
                            if (k == drop_beat) begin
                                exp_n = k + 1;
                                stop  = 1'b1;
                            end
                        end
                    end
                end
            end
        end

        @(negedge clk);
        cyc_addr = a; cyc_size = sz; cache_on = en; cache_frozen = frz;
        burst_on = ben; page_nocache = pnc; rmw_read = rmw; cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = poke;
        if (poke) cyc_addr = a ^ 32'hFFFF_0F00;
        berr_seen = 1'b0; ended = 1'b0; cyc = 0;
        while (!ended && cyc < 12) begin
            beat      = !berr_seen;
            burst_ack = (cyc == 0) ? ack0 : (cyc != drop_beat);
            berr      = !berr_seen && (cyc == berr_beat);
            ci_in     = (cyc == 0) && ci;
            #5;
            if (cyc == 0) check(tag, "burst_req", burst_req, want);
            if (beat) check(tag, "fill_addr", fill_addr, {a[31:4], 2'(st + cyc), 2'b00});
            ended = cyc_end;
            if (berr) berr_seen = 1'b1;
            cyc++;
            @(negedge clk);
        end
        cyc_start = 1'b0; beat = 1'b0; burst_ack = 1'b0; berr = 1'b0; ci_in = 1'b0;
        check(tag, "cycle length", cyc, exp_n);
        check(tag, "pending writes", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #5;
        check("R5", "reset burst_req", burst_req, 0);
        check("R5", "reset ent_we", ent_we, 0);
        check("R5", "reset cyc_end", cyc_end, 0);
        rst_n = 1'b1;
        //   tag   addr          sz  en frz ben pnc rmw ack0 drop berr ci poke
        run("R5", 32'h0000_0100, 3, 1, 0, 1, 0, 0, 1, -1, -1, 0, 0); // full burst
        run("R3", 32'h0000_0208, 3, 1, 0, 1, 0, 0, 1, -1, -1, 0, 0); // wrap 2,3,0,1
        run("R3", 32'h0000_033C, 1, 1, 0, 1, 0, 0, 1, -1, -1, 0, 0); // start at last entry
        run("R2", 32'h0000_040F, 3, 1, 0, 1, 0, 0, 1, -1, -1, 0, 0); // crossing, first part
        run("R2", 32'h0000_0410, 3, 1, 0, 1, 0, 0, 1, -1, -1, 0, 0); // second part bursts
        run("R2", 32'h0000_050E, 1, 1, 0, 1, 0, 0, 1, -1, -1, 0, 0); // word ends at 15
        run("R9", 32'h0000_0600, 3, 0, 0, 1, 0, 0, 1, -1, -1, 0, 0); // cache off
        run("R9", 32'h0000_0604, 3, 1, 1, 1, 0, 0, 1, -1, -1, 0, 0); // frozen
        run("R9", 32'h0000_0608, 3, 1, 0, 1, 1, 0, 1, -1, -1, 0, 0); // page non-cacheable
        run("R1", 32'h0000_060C, 3, 1, 0, 0, 0, 0, 1, -1, -1, 0, 0); // burst disabled
        run("R1", 32'h0000_0700, 3, 1, 0, 1, 0, 1, 1, -1, -1, 0, 0); // rmw read
        run("R4", 32'h0000_0804, 3, 1, 0, 1, 0, 0, 0, -1, -1, 0, 0); // ack not given
        run("R6", 32'h0000_0904, 3, 1, 0, 1, 0, 0, 1, -1, 0, 0, 0);  // berr first beat
        run("R6", 32'h0000_0A00, 3, 1, 0, 1, 0, 0, 1, -1, 2, 0, 0);  // berr mid burst
        run("R6", 32'h0000_0A00, 3, 1, 0, 1, 0, 0, 1, -1, 3, 0, 0);  // berr last beat
        run("R6", 32'h0000_0B08, 3, 1, 0, 0, 0, 0, 1, -1, 0, 0, 0);  // berr no burst
        run("R7", 32'h0000_0C00, 3, 1, 0, 1, 0, 0, 1, -1, -1, 1, 0); // cache inhibit
        run("R8", 32'h0000_0D04, 3, 1, 0, 1, 0, 0, 1, 2, -1, 0, 0);  // ack drop beat 2
        run("R10", 32'h0000_0E08, 3, 1, 0, 1, 0, 0, 1, -1, -1, 0, 1); // start poked while busy
        run("R1", 32'h0000_0F00, 3, 1, 0, 1, 0, 0, 1, -1, -1, 0, 0); // clean after poke
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule